// File: doc/BRIEF.md
# Hot-Swap Board Control

This block sits on the board side of a hot-swap capable add-in card. It filters the ejector-handle switch, turns each settled handle movement into an insertion or extraction status flag, and drives the enumeration event line (open-drain, active low) toward the system host and the blue LED. Software reads the flags and clears them by writing ones through a small register port. Software also owns the event mask and the LED control bit.

When the bus reset deasserts, the block captures the startup-mode strap, the two frequency straps and the 66 MHz enable input. From them it derives a bus mode/frequency code. When configuration retry mode is enabled, it also derives the configuration response policy: retry every configuration access, or leave configuration accesses unclaimed.

Top module: `hs_board_ctrl`

## Requirements
- R1: A change on `handle_raw_i` reaches the debounced handle level (register 1 bit 2) only after the synchronised input has differed from the current level for `DB_CYCLES` consecutive clocks. This is visible `DB_CYCLES`+2 rising edges after the raw change. A level that returns sooner leaves the debounced level unchanged.
- R2: A debounced handle move from open (1) to closed (0) sets insertion-pending (register 1 bit 0). A move from closed to open sets extraction-pending (register 1 bit 1).
- R3: Writing register 1 clears each pending bit whose write-data bit is 1 and leaves bits written 0 untouched. A set and a clear of the same bit on the same edge leave the bit set.
- R4: `enum_oe_o` is 1 exactly while a pending bit is set and the event mask (register 0 bit 0) is 0. `enum_do_o` is always 0.
- R5: `led_o` follows the LED control bit (register 0 bit 1), written by software.
- R6: The straps and the 66 MHz enable are captured on the first clock edge at which `bus_rst_n_i` is seen high after being low or after block reset. Strap changes at any other time have no effect.
- R7: With `cfg_retry_en_i`=1, a captured startup strap of 1 gives `cfg_retry_all_o`=1, and 0 gives `cfg_no_claim_o`=1. With `cfg_retry_en_i`=0 both outputs are 0.
- R8: `bus_mode_o` codes are: 0 = PCI 33 MHz, 1 = PCI 66 MHz, 2 = PCI-X 66, 3 = PCI-X 100, 4 = PCI-X 133, 7 = startup strap 1 (frequency straps unused). With strap 0, frequency 11 gives 1 if the 66 MHz enable is 1, otherwise 0. Frequency 10 gives 2, 01 gives 3, and 00 gives 4.
- R9: After reset, the debounced level, both pending bits, the mask and `enum_oe_o` are 0. `led_o` is 1. The captured startup strap is 1, so `bus_mode_o` is 7.
- R10: Register 2 reads bits[2:0] = mode code, bit 3 = captured startup strap, bit 4 = `cfg_retry_all_o`, bit 5 = `cfg_no_claim_o`. Register 3 reads 0. Reads are combinational from `reg_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| handle_raw_i | input | 1 | Ejector switch, 1 = open, 0 = closed |
| bus_rst_n_i | input | 1 | Active-low bus reset; rising edge captures straps |
| strap_sm_i | input | 1 | Startup-mode strap |
| strap_freq_i | input | 2 | Bus frequency/mode straps |
| m66_en_i | input | 1 | 66 MHz enable for conventional mode |
| cfg_retry_en_i | input | 1 | Configuration retry mode enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| enum_oe_o | output | 1 | Enumeration line driver enable (pull low) |
| enum_do_o | output | 1 | Enumeration line data, constant 0 |
| led_o | output | 1 | Blue LED, 1 = lit |
| bus_mode_o | output | 3 | Bus mode/frequency code |
| cfg_retry_all_o | output | 1 | Retry every configuration access |
| cfg_no_claim_o | output | 1 | Do not claim configuration accesses |

## Verification
A raw handle change reaches the debounced level and the pending bits `DB_CYCLES`+2 edges later. The bench samples one edge early to confirm nothing has moved, then samples again on the due edge. Register writes, mask changes and the LED bit take effect one edge after the write cycle. Strap results appear one edge after `bus_rst_n_i` rises. `enum_oe_o`, the policy outputs and register reads follow their sources within the same cycle. All checks sample at the falling edge or 1 ns after it, never at a rising edge.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    BM_PCI33    = 3'd0,
    BM_PCI66    = 3'd1,
    BM_PCIX66   = 3'd2,
    BM_PCIX100  = 3'd3,
    BM_PCIX133  = 3'd4,
    BM_STRAPOFF = 3'd7
  } bus_mode_e;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_STRAP  = 2'd2;

  function automatic bus_mode_e decode_bus_mode(input logic sm, input logic [1:0] freq,
                                                input logic m66);
    bus_mode_e m;
    if (sm) m = BM_STRAPOFF;
    else begin
      case (freq)
        2'b11:   m = m66 ? BM_PCI66 : BM_PCI33;
        2'b10:   m = BM_PCIX66;
        2'b01:   m = BM_PCIX100;
        default: m = BM_PCIX133;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/hs_debounce.sv
module hs_debounce #(
  parameter int DB_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic close_o,
  output logic open_o
);
  localparam int CNT_W = $clog2(DB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_CYCLES - 1);

  logic [1:0]       sync_q;
  logic             level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differ;
  logic             accept;

  assign differ  = sync_q[1] != level_q;
  assign accept  = differ && (cnt_q == CNT_LAST);
  assign close_o = accept && !sync_q[1];
  assign open_o  = accept && sync_q[1];
  assign level_o = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (accept) begin
        level_q <= sync_q[1];
        cnt_q   <= '0;
      end else if (differ) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assert_accept_after_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(cnt_q) == CNT_LAST) && (level_q == $past(sync_q[1])));
endmodule

// File: rtl/hs_strap_latch.sv
module hs_strap_latch
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst_n_i,
  input  logic       sm_i,
  input  logic [1:0] freq_i,
  input  logic       m66_i,
  input  logic       retry_en_i,
  output logic       sm_o,
  output bus_mode_e  mode_o,
  output logic       retry_all_o,
  output logic       no_claim_o
);
  logic       bus_rst_q;
  logic       capture;
  logic       sm_q;
  logic [1:0] freq_q;
  logic       m66_q;

  assign capture     = bus_rst_n_i && !bus_rst_q;
  assign sm_o        = sm_q;
  assign mode_o      = decode_bus_mode(sm_q, freq_q, m66_q);
  assign retry_all_o = retry_en_i && sm_q;
  assign no_claim_o  = retry_en_i && !sm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rst_q <= 1'b0;
      sm_q      <= 1'b1;
      freq_q    <= 2'b00;
      m66_q     <= 1'b0;
    end else begin
      bus_rst_q <= bus_rst_n_i;
      if (capture) begin
        sm_q   <= sm_i;
        freq_q <= freq_i;
        m66_q  <= m66_i;
      end
    end
  end

  assert_strap_only_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(capture) |-> $stable(sm_q) && $stable(freq_q) && $stable(m66_q));
  assert_policy_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_all_o, no_claim_o}));
endmodule

// File: rtl/hs_event_regs.sv
module hs_event_regs
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ins_set_i,
  input  logic       ext_set_i,
  input  logic       level_i,
  input  logic [5:0] strap_word_i,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       enum_oe_o,
  output logic       led_o
);
  logic mask_q, led_q, ins_q, ext_q;
  logic wr_ctrl, wr_status;
  logic ins_clr, ext_clr;

  assign wr_ctrl   = wr_i && (addr_i == ADDR_CTRL);
  assign wr_status = wr_i && (addr_i == ADDR_STATUS);
  assign ins_clr   = wr_status && wdata_i[0];
  assign ext_clr   = wr_status && wdata_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      led_q  <= 1'b1;
      ins_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mask_q <= wdata_i[0];
        led_q  <= wdata_i[1];
      end
      if (ins_set_i)    ins_q <= 1'b1;
      else if (ins_clr) ins_q <= 1'b0;
      if (ext_set_i)    ext_q <= 1'b1;
      else if (ext_clr) ext_q <= 1'b0;
    end
  end

  assign enum_oe_o = (ins_q || ext_q) && !mask_q;
  assign led_o     = led_q;

  always_comb begin
    case (addr_i)
      ADDR_CTRL:   rdata_o = {6'd0, led_q, mask_q};
      ADDR_STATUS: rdata_o = {5'd0, level_i, ext_q, ins_q};
      ADDR_STRAP:  rdata_o = {2'd0, strap_word_i};
      default:     rdata_o = 8'd0;
    endcase
  end

  assert_insert_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_set_i |=> ins_q);
  assert_extract_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_set_i |=> ext_q);
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_clr && !ins_set_i |=> !ins_q);
  assert_led_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(led_o));
endmodule

// File: rtl/hs_board_ctrl.sv
module hs_board_ctrl
  import hs_pkg::*;
#(
  parameter int DB_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       handle_raw_i,
  input  logic       bus_rst_n_i,
  input  logic       strap_sm_i,
  input  logic [1:0] strap_freq_i,
  input  logic       m66_en_i,
  input  logic       cfg_retry_en_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       enum_oe_o,
  output logic       enum_do_o,
  output logic       led_o,
  output logic [2:0] bus_mode_o,
  output logic       cfg_retry_all_o,
  output logic       cfg_no_claim_o
);
  logic      handle_level;
  logic      handle_closed_evt;
  logic      handle_opened_evt;
  logic      strap_sm;
  bus_mode_e mode;
  logic      retry_all, no_claim;

  hs_debounce #(.DB_CYCLES(DB_CYCLES)) u_debounce (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (handle_raw_i),
    .level_o (handle_level),
    .close_o (handle_closed_evt),
    .open_o  (handle_opened_evt)
  );

  hs_strap_latch u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rst_n_i (bus_rst_n_i),
    .sm_i        (strap_sm_i),
    .freq_i      (strap_freq_i),
    .m66_i       (m66_en_i),
    .retry_en_i  (cfg_retry_en_i),
    .sm_o        (strap_sm),
    .mode_o      (mode),
    .retry_all_o (retry_all),
    .no_claim_o  (no_claim)
  );

  hs_event_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_set_i    (handle_closed_evt),
    .ext_set_i    (handle_opened_evt),
    .level_i      (handle_level),
    .strap_word_i ({no_claim, retry_all, strap_sm, mode}),
    .wr_i         (reg_wr_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .enum_oe_o    (enum_oe_o),
    .led_o        (led_o)
  );

  assign enum_do_o       = 1'b0;
  assign bus_mode_o      = mode;
  assign cfg_retry_all_o = retry_all;
  assign cfg_no_claim_o  = no_claim;

  assert_enum_data_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enum_do_o == 1'b0);
  assert_event_drives_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (handle_closed_evt || handle_opened_evt) && !reg_wr_i && !(reg_rdata_o[0] && reg_addr_i == ADDR_CTRL)
    |=> enum_oe_o || $past(reg_addr_i) == ADDR_CTRL);
endmodule

// File: tb/hs_board_ctrl_tb.sv
module hs_board_ctrl_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       handle_raw = 1'b0;
  logic       bus_rst_n = 1'b0;
  logic       sm = 1'b1;
  logic [1:0] freq = 2'b00;
  logic       m66 = 1'b0;
  logic       retry_en = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       enum_oe, enum_do, led;
  logic [2:0] bus_mode;
  logic       retry_all, no_claim;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  hs_board_ctrl #(.DB_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .handle_raw_i(handle_raw), .bus_rst_n_i(bus_rst_n),
    .strap_sm_i(sm), .strap_freq_i(freq), .m66_en_i(m66), .cfg_retry_en_i(retry_en),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .enum_oe_o(enum_oe), .enum_do_o(enum_do), .led_o(led), .bus_mode_o(bus_mode),
    .cfg_retry_all_o(retry_all), .cfg_no_claim_o(no_claim)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_mode(input int s, input int f, input int m);
    if (s == 1) return 7;
    if (f == 3) return m;
    return 4 - f;
  endfunction

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr = 1'b0; wdata = 8'd0;
  endtask

  task automatic move_handle(input logic v);
    handle_raw = v;
    repeat (N + 2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(2'd1, d); chk("R9 status", d, 0);
    rd(2'd0, d); chk("R9 ctrl", d, 2);
    chk("R9 led", led, 1);
    chk("R9 enum_oe", enum_oe, 0);
    chk("R9 bus_mode", bus_mode, 7);
    chk("R4 enum_do", enum_do, 0);

    // R1 timing: open handle
    @(negedge clk);
    handle_raw = 1'b1;
    repeat (N + 1) @(posedge clk);
    @(negedge clk);
    rd(2'd1, d); chk("R1 not yet", d, 0);
    @(posedge clk); @(negedge clk);
    rd(2'd1, d); chk("R1/R2 extraction level+pending", d, 6);
    chk("R4 enum asserted", enum_oe, 1);

    // R3 write 0 has no effect, write 1 clears
    wr_reg(2'd1, 8'h01);
    rd(2'd1, d); chk("R3 write of other bit ignored", d, 6);
    wr_reg(2'd1, 8'h02);
    rd(2'd1, d); chk("R3 clear extraction", d, 4);
    chk("R4 enum released", enum_oe, 0);

    // R1 bounce shorter than window
    handle_raw = 1'b0;
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    handle_raw = 1'b1;
    repeat (N + 4) @(posedge clk);
    @(negedge clk);
    rd(2'd1, d); chk("R1 bounce ignored", d, 4);

    // R4 mask, R2 insertion
    wr_reg(2'd0, 8'h03);
    move_handle(1'b0);
    rd(2'd1, d); chk("R2 insertion pending", d, 1);
    chk("R4 masked", enum_oe, 0);
    wr_reg(2'd0, 8'h02);
    chk("R4 unmasked", enum_oe, 1);

    // R3 set wins over clear on the same edge
    wr_reg(2'd1, 8'h01);
    handle_raw = 1'b1;
    repeat (N + 1) @(posedge clk);
    @(negedge clk);
    wr = 1'b1; addr = 2'd1; wdata = 8'h02;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
    rd(2'd1, d); chk("R3 set beats clear", d, 6);
    wr_reg(2'd1, 8'h03);

    // R5 LED control
    wr_reg(2'd0, 8'h00);
    chk("R5 led off", led, 0);
    wr_reg(2'd0, 8'h02);
    chk("R5 led on", led, 1);

    // R6/R7/R8/R10 sweep of all strap combinations
    for (int k = 0; k < 32; k++) begin
      int s, f, m, re, em;
      s = (k >> 4) & 1; f = (k >> 2) & 3; m = (k >> 1) & 1; re = k & 1;
      bus_rst_n = 1'b0;
      sm = s[0]; freq = f[1:0]; m66 = m[0]; retry_en = re[0];
      @(posedge clk); @(negedge clk);
      bus_rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      em = exp_mode(s, f, m);
      chk("R8 mode", bus_mode, em);
      chk("R7 retry_all", retry_all, re & s);
      chk("R7 no_claim", no_claim, re & (1 - s));
      rd(2'd2, d);
      chk("R10 strap reg", d, em + s * 8 + (re & s) * 16 + (re & (1 - s)) * 32);
      sm = ~sm; freq = ~freq; m66 = ~m66;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R6 late strap ignored", bus_mode, em);
    end
    rd(2'd3, d); chk("R10 unused reads 0", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule